// File: doc/BRIEF.md
# Direct Control Bus Write Unit

This block carries out a privileged write from a processor core to an element elsewhere in the system, over a dedicated control bus. The core supplies the element-select half of an already computed, word-aligned effective address, the 4-bit index of the source register and that register's 32-bit contents. The block places the element address and write data on the bus with a one-cycle strobe. It then waits for the addressed device to acknowledge, and turns the status the device returns into a 4-bit condition code.

The upper four bits of the element address are a mode field. The mode selects a class of target: internal processor control, interrupt control, test equipment, unassigned, or special user-defined system control. The mode also decides how the condition code is formed. Naming register 0 as the source sends all zeros, not the contents of that register. A request made outside privileged state never reaches the bus and raises a trap instead. A device that stays silent is cut off after a fixed number of cycles, and this sets an error flag.

Top module: `dcb_write_unit`

## Requirements
- R1: After reset, busy_o, bus_wvalid_o, trap_o, done_o and timeout_o are 0, and cc_o is 4'b0000.
- R2: A request (req_i=1, priv_i=1) seen at a clock edge while busy_o=0 raises bus_wvalid_o for exactly the next cycle, with busy_o=1. In that cycle bus_addr_o equals the elem_addr_i captured at the edge, and timeout_o is 0.
- R3: The strobed bus_data_o equals rdata_i when rfield_i is nonzero, and equals 32'h0 when rfield_i is 0.
- R4: A request with priv_i=0 while busy_o=0 pulses trap_o for the next cycle only. In that case there is no strobe, busy_o stays 0 and cc_o is unchanged.
- R5: A request seen while busy_o=1, privileged or not, is ignored: it gives no strobe and no trap.
- R6: When bus_ack_i=1 in a busy cycle, busy_o is 0 and done_o is 1 in the following cycle, and done_o lasts one cycle.
- R7: The mode is bus_addr_o[15:12]. For modes 2 through 15, an acknowledge loads cc_o with {2'b00, bus_ccl_i[1], bus_ccl_i[0]}, sampled in the acknowledge cycle. cc_o[3] is the first condition-code bit.
- R8: For modes 0 and 1, an acknowledge loads cc_o with int_cc_i if int_ccv_i=1 in that cycle. Otherwise cc_o keeps its value.
- R9: Without an acknowledge, busy_o stays high for exactly TIMEOUT_CYC cycles counting the strobe cycle, then falls. At that point timeout_o rises and cc_o is unchanged. timeout_o stays high until the next accepted privileged request.
- R10: tgt_class_o is captured with the strobe from the mode. The encoding is: mode 0 gives 0 (internal), mode 1 gives 1 (interrupt), modes 2-3 give 2 (test), modes 4-7 give 3 (unassigned) and modes 8-15 give 4 (special).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request to execute a direct write |
| priv_i | input | 1 | Processor is in privileged state |
| elem_addr_i | input | 16 | Element-select half of the effective address |
| rfield_i | input | 4 | Source register index |
| rdata_i | input | 32 | Contents of the named register |
| bus_addr_o | output | 16 | Control bus element address |
| bus_data_o | output | 32 | Control bus write data |
| bus_wvalid_o | output | 1 | One-cycle write strobe |
| tgt_class_o | output | 3 | Decoded target class of the current operation |
| bus_ack_i | input | 1 | Device acknowledge |
| bus_ccl_i | input | 2 | Device condition-code lines |
| int_ccv_i | input | 1 | Internal or interrupt target supplies a condition code |
| int_cc_i | input | 4 | Condition code from internal or interrupt target |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse on acknowledge completion |
| timeout_o | output | 1 | No acknowledge within the timeout window |
| trap_o | output | 1 | One-cycle privilege-violation trap |
| cc_o | output | 4 | Condition code result |

## Verification
The assertions assume that the acknowledge is meaningful only while busy_o is high. They assume that the source register inputs are stable at the edge that accepts a request, and that the device lines are valid in the cycle of the acknowledge. The stimulus drives every input half a cycle before the edge that samples it. It raises bus_ack_i only inside a busy window and drops it in the next cycle, so a stray acknowledge never arrives while the block is idle. Requests sent during busy windows alternate between privileged and unprivileged, so the ignore rule is exercised under both states.

// File: rtl/dcbw_pkg.sv
package dcbw_pkg;

  localparam int ELEM_W = 16;
  localparam int DATA_W = 32;
  localparam int RF_W   = 4;
  localparam int CC_W   = 4;
  localparam int CCL_W  = 2;
  localparam int MODE_W = 4;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    TGT_INTERNAL   = 3'd0,
    TGT_INTERRUPT  = 3'd1,
    TGT_TEST       = 3'd2,
    TGT_UNASSIGNED = 3'd3,
    TGT_SPECIAL    = 3'd4
  } tgt_class_e;

  // Mode lives in the top nibble of the element address.
  function automatic logic [MODE_W-1:0] f_mode(input logic [ELEM_W-1:0] a);
    return a[ELEM_W-1 -: MODE_W];
  endfunction

  function automatic tgt_class_e f_class(input logic [MODE_W-1:0] m);
    if (m == 4'd0)      return TGT_INTERNAL;
    else if (m == 4'd1) return TGT_INTERRUPT;
    else if (m < 4'd4)  return TGT_TEST;
    else if (m < 4'd8)  return TGT_UNASSIGNED;
    else                return TGT_SPECIAL;
  endfunction

  // Register 0 means "send zeros", never the register contents.
  function automatic logic [DATA_W-1:0] f_wdata(input logic [RF_W-1:0] rf,
                                                input logic [DATA_W-1:0] rd);
    return (rf == '0) ? '0 : rd;
  endfunction

  function automatic logic f_device_cc(input logic [MODE_W-1:0] m);
    return m >= 4'd2;
  endfunction

  function automatic logic [CC_W-1:0] f_cc_from_lines(input logic [CCL_W-1:0] l);
    return {{(CC_W-CCL_W){1'b0}}, l};
  endfunction

endpackage

// File: rtl/dcbw_launch.sv
module dcbw_launch
  import dcbw_pkg::*;
#(
  parameter int EW = ELEM_W,
  parameter int DW = DATA_W,
  parameter int RW = RF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            priv_i,
  input  logic            busy_i,
  input  logic [EW-1:0]   elem_addr_i,
  input  logic [RW-1:0]   rfield_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            start_fire_o,
  output logic [EW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_data_o,
  output logic            bus_wvalid_o,
  output logic [CLS_W-1:0] tgt_class_o,
  output logic            trap_o
);

  logic accept;
  logic trap_fire;

  assign accept       = req_i & ~busy_i;
  assign start_fire_o = accept & priv_i;
  assign trap_fire    = accept & ~priv_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_addr_o   <= '0;
      bus_data_o   <= '0;
      bus_wvalid_o <= 1'b0;
      tgt_class_o  <= '0;
      trap_o       <= 1'b0;
    end else begin
      bus_wvalid_o <= start_fire_o;
      trap_o       <= trap_fire;
      if (start_fire_o) begin
        bus_addr_o  <= elem_addr_i;
        bus_data_o  <= f_wdata(rfield_i, rdata_i);
        tgt_class_o <= f_class(f_mode(elem_addr_i));
      end
    end
  end

endmodule

// File: rtl/dcbw_seq.sv
module dcbw_seq #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_fire_i,
  input  logic bus_ack_i,
  output logic busy_o,
  output logic ack_take_o,
  output logic to_fire_o,
  output logic done_o,
  output logic timeout_o
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign ack_take_o = busy_o & bus_ack_i;
  assign to_fire_o  = busy_o & ~bus_ack_i & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o    <= 1'b0;
      cnt       <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= ack_take_o;
      if (start_fire_i) begin
        busy_o    <= 1'b1;
        cnt       <= '0;
        timeout_o <= 1'b0;
      end else if (ack_take_o) begin
        busy_o <= 1'b0;
      end else if (to_fire_o) begin
        busy_o    <= 1'b0;
        timeout_o <= 1'b1;
      end else if (busy_o) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcbw_ccreg.sv
module dcbw_ccreg
  import dcbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_take_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CCL_W-1:0]  bus_ccl_i,
  input  logic              int_ccv_i,
  input  logic [CC_W-1:0]   int_cc_i,
  output logic [CC_W-1:0]   cc_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_o <= '0;
    end else if (ack_take_i) begin
      if (f_device_cc(mode_i))
        cc_o <= f_cc_from_lines(bus_ccl_i);
      else if (int_ccv_i)
        cc_o <= int_cc_i;
    end
  end

endmodule

// File: rtl/dcb_write_unit.sv
module dcb_write_unit
  import dcbw_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               priv_i,
  input  logic [ELEM_W-1:0]  elem_addr_i,
  input  logic [RF_W-1:0]    rfield_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [ELEM_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]  bus_data_o,
  output logic               bus_wvalid_o,
  output logic [CLS_W-1:0]   tgt_class_o,
  input  logic               bus_ack_i,
  input  logic [CCL_W-1:0]   bus_ccl_i,
  input  logic               int_ccv_i,
  input  logic [CC_W-1:0]    int_cc_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic               trap_o,
  output logic [CC_W-1:0]    cc_o
);

  logic start_fire;
  logic ack_take;
  logic to_fire;
  logic [MODE_W-1:0] cur_mode;

  assign cur_mode = f_mode(bus_addr_o);

  dcbw_launch u_launch (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .priv_i       (priv_i),
    .busy_i       (busy_o),
    .elem_addr_i  (elem_addr_i),
    .rfield_i     (rfield_i),
    .rdata_i      (rdata_i),
    .start_fire_o (start_fire),
    .bus_addr_o   (bus_addr_o),
    .bus_data_o   (bus_data_o),
    .bus_wvalid_o (bus_wvalid_o),
    .tgt_class_o  (tgt_class_o),
    .trap_o       (trap_o)
  );

  dcbw_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_fire_i (start_fire),
    .bus_ack_i    (bus_ack_i),
    .busy_o       (busy_o),
    .ack_take_o   (ack_take),
    .to_fire_o    (to_fire),
    .done_o       (done_o),
    .timeout_o    (timeout_o)
  );

  dcbw_ccreg u_cc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_take_i (ack_take),
    .mode_i     (cur_mode),
    .bus_ccl_i  (bus_ccl_i),
    .int_ccv_i  (int_ccv_i),
    .int_cc_i   (int_cc_i),
    .cc_o       (cc_o)
  );

endmodule

// File: rtl/dcbw_checker.sv
module dcbw_checker #(
  parameter int TIMEOUT_CYC = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        priv_i,
  input logic [15:0] elem_addr_i,
  input logic [3:0]  rfield_i,
  input logic [31:0] rdata_i,
  input logic [15:0] bus_addr_o,
  input logic [31:0] bus_data_o,
  input logic        bus_wvalid_o,
  input logic        bus_ack_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        timeout_o,
  input logic        trap_o,
  input logic [3:0]  cc_o,
  input logic        ack_take,
  input logic        to_fire
);

  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  logic [CW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid_o |=> !bus_wvalid_o); // R2
  AST_STROBE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid_o |-> busy_o && !$past(busy_o) && $past(req_i && priv_i)); // R2
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid_o |-> bus_addr_o == $past(elem_addr_i)); // R2
  AST_DATA_ZERO_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid_o |-> bus_data_o == (($past(rfield_i) == 4'd0) ? 32'd0 : $past(rdata_i))); // R3
  AST_TRAP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !bus_wvalid_o && !busy_o && $past(req_i && !priv_i && !busy_o)); // R4
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) && busy_o |-> !bus_wvalid_o && !trap_o); // R5
  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> done_o && !busy_o); // R6
  AST_CC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cc_o) |-> $past(busy_o && bus_ack_i)); // R8
  AST_CC_DEVICE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cc_o) && bus_addr_o[15:12] >= 4'd2 |-> cc_o[3:2] == 2'b00); // R7
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> busy_run < CW'(TIMEOUT_CYC)); // R9
  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    to_fire |=> timeout_o && !busy_o && $stable(cc_o)); // R9

endmodule

bind dcb_write_unit dcbw_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .priv_i       (priv_i),
  .elem_addr_i  (elem_addr_i),
  .rfield_i     (rfield_i),
  .rdata_i      (rdata_i),
  .bus_addr_o   (bus_addr_o),
  .bus_data_o   (bus_data_o),
  .bus_wvalid_o (bus_wvalid_o),
  .bus_ack_i    (bus_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .timeout_o    (timeout_o),
  .trap_o       (trap_o),
  .cc_o         (cc_o),
  .ack_take     (ack_take),
  .to_fire      (to_fire)
);

// File: tb/dcb_write_unit_tb.sv
module dcb_write_unit_tb_top;

  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, priv_i = 1'b0;
  logic [15:0] elem_addr_i = '0;
  logic [3:0]  rfield_i = '0;
  logic [31:0] rdata_i = '0;
  logic [15:0] bus_addr_o;
  logic [31:0] bus_data_o;
  logic        bus_wvalid_o;
  logic [2:0]  tgt_class_o;
  logic        bus_ack_i = 1'b0;
  logic [1:0]  bus_ccl_i = '0;
  logic        int_ccv_i = 1'b0;
  logic [3:0]  int_cc_i = '0;
  logic        busy_o, done_o, timeout_o, trap_o;
  logic [3:0]  cc_o;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_cc = 4'd0;

  always #2 clk = ~clk;

  dcb_write_unit #(.TIMEOUT_CYC(TO)) dut_i (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] class_of(input int m);
    if (m == 0) return 3'd0;
    if (m == 1) return 3'd1;
    if (m <= 3) return 3'd2;
    if (m <= 7) return 3'd3;
    return 3'd4;
  endfunction

  // Launch a privileged op; returns after the strobe cycle was checked.
  task automatic launch(input int m, input logic [11:0] lo, input logic [3:0] rf,
                        input logic [31:0] rd);
    req_i = 1'b1; priv_i = 1'b1;
    elem_addr_i = {m[3:0], lo}; rfield_i = rf; rdata_i = rd;
    @(negedge clk);
    req_i = 1'b0;
    chk(bus_wvalid_o === 1'b1 && busy_o === 1'b1, "R2 strobe", {bus_wvalid_o, busy_o}, 2'b11);
    chk(bus_addr_o === {m[3:0], lo}, "R2 addr", bus_addr_o, {m[3:0], lo});
    chk(timeout_o === 1'b0, "R9 timeout cleared", timeout_o, 0);
    chk(bus_data_o === ((rf == 0) ? 32'd0 : rd), "R3 data", bus_data_o,
        (rf == 0) ? 32'd0 : rd);
    chk(tgt_class_o === class_of(m), "R10 class", tgt_class_o, class_of(m));
  endtask

  task automatic run_op(input int m, input logic [11:0] lo, input logic [3:0] rf,
                        input logic [31:0] rd, input int dly, input logic [1:0] ccl,
                        input logic iv, input logic [3:0] ic);
    launch(m, lo, rf, rd);
    for (int i = 0; i < dly; i++) begin
      req_i = 1'b1; priv_i = i[0];
      @(negedge clk);
      chk(bus_wvalid_o === 1'b0 && trap_o === 1'b0 && busy_o === 1'b1, "R5 ignored",
          {bus_wvalid_o, trap_o, busy_o}, 3'b001);
    end
    req_i = 1'b0;
    bus_ack_i = 1'b1; bus_ccl_i = ccl; int_ccv_i = iv; int_cc_i = ic;
    @(negedge clk);
    bus_ack_i = 1'b0; int_ccv_i = 1'b0;
    if (m >= 2) exp_cc = {2'b00, ccl};
    else if (iv) exp_cc = ic;
    chk(busy_o === 1'b0 && done_o === 1'b1, "R6 done", {busy_o, done_o}, 2'b01);
    chk(cc_o === exp_cc, (m >= 2) ? "R7 device cc" : "R8 internal cc", cc_o, exp_cc);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done single", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o === 0 && bus_wvalid_o === 0 && trap_o === 0 && done_o === 0 &&
        timeout_o === 0 && cc_o === 4'd0, "R1 reset",
        {busy_o, bus_wvalid_o, trap_o, done_o, timeout_o, cc_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 16; m++) begin
      for (int v = 0; v < 4; v++) begin
        run_op(m, 12'(m * 37 + v), (v == 0) ? 4'd0 : 4'(v * 3 + 1),
               32'hA5C3_0F00 ^ (m * 32'h0101_0101) ^ v, (m + v) % 4,
               2'(v ^ m), v[0], 4'(m ^ (v * 5)));
      end
    end

    // Timeout: no acknowledge at all.
    launch(5, 12'h3C1, 4'd7, 32'hDEAD_BEEF);
    for (int i = 1; i < TO; i++) begin
      @(negedge clk);
      chk(busy_o === 1'b1 && timeout_o === 1'b0, "R9 still busy", {busy_o, timeout_o}, 2'b10);
    end
    @(negedge clk);
    chk(busy_o === 1'b0 && timeout_o === 1'b1, "R9 timeout", {busy_o, timeout_o}, 2'b01);
    chk(cc_o === exp_cc, "R9 cc unchanged", cc_o, exp_cc);

    // Unprivileged attempt.
    req_i = 1'b1; priv_i = 1'b0; elem_addr_i = 16'h9ABC;
    @(negedge clk);
    req_i = 1'b0;
    chk(trap_o === 1'b1 && bus_wvalid_o === 1'b0 && busy_o === 1'b0, "R4 trap",
        {trap_o, bus_wvalid_o, busy_o}, 3'b100);
    @(negedge clk);
    chk(trap_o === 1'b0 && busy_o === 1'b0, "R4 trap single", {trap_o, busy_o}, 0);
    chk(cc_o === exp_cc, "R4 cc unchanged", cc_o, exp_cc);
    chk(timeout_o === 1'b1, "R9 timeout held", timeout_o, 1);

    // Next op clears the timeout flag; mode 1 without a supplied value keeps cc.
    run_op(1, 12'h001, 4'd0, 32'h1234_5678, 2, 2'b11, 1'b0, 4'hF);
    run_op(15, 12'hFFF, 4'd15, 32'hFFFF_FFFF, 0, 2'b10, 1'b1, 4'hF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule